// File: doc/BRIEF.md
# Float and Integer Zero Comparator

This unit compares a 64-bit operand against zero with no subtraction. It splits the operand into a sign bit, an 11-bit exponent and a 52-bit fraction. It reduces those fields to a handful of terms, such as "exponent all zero", "exponent all ones" and "fraction all zero". From these terms it builds a condition vector that a branch or set-on-condition stage can use directly.

A two-bit mode input chooses how the operand is read:
- binary64 floating point;
- signed integer;
- unsigned integer.

The floating-point corner cases are settled by classifying the fields:
- negative zero equals positive zero;
- NaN is unordered;
- denormals are nonzero;
- infinities take their place in the sign ordering with no logic of their own.

The integer modes use the same field terms.

The unit is purely combinational. Its outputs are valid in the same cycle as its inputs. A 4-bit condition code picks one bit of the condition vector as a single hit output.

Top module: `zcmp_top`

## Requirements
- R1: `class_oh` is one-hot at all times, with bit 0 for zero, bit 1 for negative, bit 2 for positive and bit 3 for unordered (NaN).
- R2: In floating-point mode (mode 0), an operand whose exponent and fraction are both all zero is classed zero and satisfies EQ, LE and GE, whatever its sign bit.
- R3: In floating-point mode, an all-ones exponent with a nonzero fraction (quiet or signaling NaN) is classed unordered. EQ, LT, LE, GT, GE and ORDERED are then false, while NE and UNORDERED are true.
- R4: In floating-point mode, a zero exponent with a nonzero fraction is nonzero. It sets IS_DENORM and is ordered by its sign bit.
- R5: In floating-point mode, an all-ones exponent with a zero fraction sets IS_INF and is ordered by its sign bit, like any finite value.
- R6: In signed mode (mode 1), only the all-zero word is zero. Any word with bit 63 set is negative, and every other word is positive.
- R7: In unsigned mode (mode 2, and also mode 3), LT is always false, GE is always true, and GT equals NE.
- R8: In both integer modes, ORDERED is true, and UNORDERED, IS_INF and IS_DENORM are false.
- R9: `cond_vec` bit positions follow these codes: 0 EQ, 1 NE, 2 LT, 3 LE, 4 GT, 5 GE, 6 ORDERED, 7 UNORDERED, 8 IS_INF, 9 IS_DENORM. `cond_hit` equals the bit that `cond_sel` names, and it is 0 for codes 10 to 15.
- R10: All outputs depend only on the current inputs, with no register on any path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand | input | 64 | Value compared against zero |
| mode | input | 2 | 0 float, 1 signed, 2 or 3 unsigned |
| cond_sel | input | 4 | Condition code to select |
| class_oh | output | 4 | One-hot class: zero, negative, positive, unordered |
| cond_vec | output | 10 | All conditions, indexed by code |
| cond_hit | output | 1 | Selected condition bit |

## Verification
Each operand in the set is applied in all four modes and with all sixteen condition codes:
- both zeros;
- the smallest and largest denormals;
- positive and negative normals;
- both infinities;
- quiet, signaling and negative NaNs;
- integer minus one and the largest positive integer.

The pairs that differ only in sign separate a magnitude-based zero test from a bitwise one. The NaN and infinity pairs separate a correct fraction check from one that looks at the exponent alone. Running the same words through the integer modes shows whether the float-only flags leak into integer results, and whether the unsigned mode ever reports a negative value.

// File: rtl/zcmp_pkg.sv
package zcmp_pkg;

  localparam int unsigned OPND_W = 64;
  localparam int unsigned EXPN_W = 11;
  localparam int unsigned FRAC_W = OPND_W - EXPN_W - 1;
  localparam int unsigned CSEL_W = 4;
  localparam int unsigned NCOND  = 10;
  localparam int unsigned NCLASS = 4;

  typedef enum logic [1:0] {
    MODE_FP   = 2'd0,
    MODE_SINT = 2'd1,
    MODE_UINT = 2'd2,
    MODE_ALTU = 2'd3
  } zmode_e;

  // Positions in the one-hot class vector
  localparam int unsigned CL_ZERO = 0;
  localparam int unsigned CL_NEG  = 1;
  localparam int unsigned CL_POS  = 2;
  localparam int unsigned CL_UNO  = 3;

  // Condition codes; also bit positions in the condition vector
  localparam int unsigned CC_EQ    = 0;
  localparam int unsigned CC_NE    = 1;
  localparam int unsigned CC_LT    = 2;
  localparam int unsigned CC_LE    = 3;
  localparam int unsigned CC_GT    = 4;
  localparam int unsigned CC_GE    = 5;
  localparam int unsigned CC_ORD   = 6;
  localparam int unsigned CC_UNORD = 7;
  localparam int unsigned CC_INF   = 8;
  localparam int unsigned CC_DEN   = 9;

  typedef struct packed {
    logic sign;
    logic exp_zero;
    logic exp_ones;
    logic frac_zero;
  } zfield_t;

endpackage

// File: rtl/zcmp_field_split.sv
module zcmp_field_split
  import zcmp_pkg::*;
#(
  parameter int unsigned W_OPND = OPND_W,
  parameter int unsigned W_EXPN = EXPN_W
) (
  input  logic [W_OPND-1:0] opnd,
  output zfield_t           fld
);

  localparam int unsigned W_FRAC = W_OPND - W_EXPN - 1;
  localparam int unsigned EXP_LO = W_FRAC;
  localparam int unsigned EXP_HI = W_FRAC + W_EXPN - 1;

  logic [W_EXPN-1:0] expn;
  logic [W_FRAC-1:0] frac;

  assign expn = opnd[EXP_HI:EXP_LO];
  assign frac = opnd[W_FRAC-1:0];

  always_comb begin
    fld.sign      = opnd[W_OPND-1];
    fld.exp_zero  = ~(|expn);
    fld.exp_ones  = &expn;
    fld.frac_zero = ~(|frac);
  end

endmodule

// File: rtl/zcmp_classify.sv
module zcmp_classify
  import zcmp_pkg::*;
(
  input  logic [1:0]        mode,
  input  zfield_t           fld,
  output logic [NCLASS-1:0] cls,
  output logic              is_inf,
  output logic              is_den
);

  logic fp_mode;
  logic signed_mode;
  logic mag_zero;
  logic fp_nan;

  always_comb begin
    fp_mode     = (mode == MODE_FP);
    signed_mode = (mode == MODE_SINT);
    // Every bit below the sign is clear
    mag_zero    = fld.exp_zero & fld.frac_zero;
    fp_nan      = fld.exp_ones & ~fld.frac_zero;
  end

  always_comb begin
    cls    = '0;
    is_inf = 1'b0;
    is_den = 1'b0;
    if (fp_mode) begin
      is_inf = fld.exp_ones & fld.frac_zero;
      is_den = fld.exp_zero & ~fld.frac_zero;
      if (fp_nan)        cls[CL_UNO]  = 1'b1;
      else if (mag_zero) cls[CL_ZERO] = 1'b1;
      else if (fld.sign) cls[CL_NEG]  = 1'b1;
      else               cls[CL_POS]  = 1'b1;
    end else if (signed_mode) begin
      if (fld.sign)      cls[CL_NEG]  = 1'b1;
      else if (mag_zero) cls[CL_ZERO] = 1'b1;
      else               cls[CL_POS]  = 1'b1;
    end else begin
      if (mag_zero & ~fld.sign) cls[CL_ZERO] = 1'b1;
      else                      cls[CL_POS]  = 1'b1;
    end
  end

endmodule

// File: rtl/zcmp_cond_map.sv
module zcmp_cond_map
  import zcmp_pkg::*;
#(
  parameter int unsigned N_COND = NCOND,
  parameter int unsigned W_CSEL = CSEL_W
) (
  input  logic [NCLASS-1:0] cls,
  input  logic              is_inf,
  input  logic              is_den,
  input  logic [W_CSEL-1:0] sel,
  output logic [N_COND-1:0] cvec,
  output logic              hit
);

  logic [NCOND-1:0] base;

  always_comb begin
    base            = '0;
    base[CC_EQ]     = cls[CL_ZERO];
    base[CC_NE]     = ~cls[CL_ZERO];
    base[CC_LT]     = cls[CL_NEG];
    base[CC_LE]     = cls[CL_NEG] | cls[CL_ZERO];
    base[CC_GT]     = cls[CL_POS];
    base[CC_GE]     = cls[CL_POS] | cls[CL_ZERO];
    base[CC_ORD]    = ~cls[CL_UNO];
    base[CC_UNORD]  = cls[CL_UNO];
    base[CC_INF]    = is_inf;
    base[CC_DEN]    = is_den;
  end

  for (genvar g = 0; g < N_COND; g++) begin : g_cond
    if (g < NCOND) begin : g_used
      assign cvec[g] = base[g];
    end else begin : g_spare
      assign cvec[g] = 1'b0;
    end
  end

  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < N_COND; i++) begin
      if (sel == W_CSEL'(i)) hit = cvec[i];
    end
  end

endmodule

// File: rtl/zcmp_top.sv
module zcmp_top
  import zcmp_pkg::*;
(
  input  logic [63:0] operand,
  input  logic [1:0]  mode,
  input  logic [3:0]  cond_sel,
  output logic [3:0]  class_oh,
  output logic [9:0]  cond_vec,
  output logic        cond_hit
);

  zfield_t fld;
  logic    inf_flag;
  logic    den_flag;

  zcmp_field_split #(
    .W_OPND (OPND_W),
    .W_EXPN (EXPN_W)
  ) u_split (
    .opnd (operand),
    .fld  (fld)
  );

  zcmp_classify u_class (
    .mode   (mode),
    .fld    (fld),
    .cls    (class_oh),
    .is_inf (inf_flag),
    .is_den (den_flag)
  );

  zcmp_cond_map #(
    .N_COND (NCOND),
    .W_CSEL (CSEL_W)
  ) u_map (
    .cls    (class_oh),
    .is_inf (inf_flag),
    .is_den (den_flag),
    .sel    (cond_sel),
    .cvec   (cond_vec),
    .hit    (cond_hit)
  );

endmodule

// File: rtl/zcmp_checker.sv
module zcmp_checker (
  input logic [63:0] operand,
  input logic [1:0]  mode,
  input logic [3:0]  cond_sel,
  input logic [3:0]  class_oh,
  input logic [9:0]  cond_vec,
  input logic        cond_hit
);

  always_comb begin
    a_r1_class_onehot: assert ($onehot(class_oh))
      else $error("class vector not one-hot");

    if (mode == 2'd0 && operand[62:0] == 63'd0) begin
      a_r2_signed_zero_eq: assert (cond_vec[0] && cond_vec[3] && cond_vec[5])
        else $error("float zero of either sign not equal");
    end

    if (mode == 2'd0 && (&operand[62:52]) && (|operand[51:0])) begin
      a_r3_nan_unordered: assert (cond_vec[7] && !cond_vec[6] && !cond_vec[0] &&
                                  !cond_vec[2] && !cond_vec[3] && !cond_vec[4] &&
                                  !cond_vec[5])
        else $error("NaN reported as ordered");
    end

    if (mode == 2'd0 && operand[62:52] == 11'd0 && (|operand[51:0])) begin
      a_r4_denorm_nonzero: assert (!cond_vec[0] && cond_vec[9])
        else $error("denormal treated as zero");
    end

    if (mode[1]) begin
      a_r7_unsigned_order: assert (!cond_vec[2] && cond_vec[5] &&
                                   (cond_vec[4] == cond_vec[1]))
        else $error("unsigned ordering broken");
    end

    if (mode != 2'd0) begin
      a_r8_int_no_fp_flags: assert (cond_vec[6] && !cond_vec[7] &&
                                    !cond_vec[8] && !cond_vec[9])
        else $error("float flag in integer mode");
    end

    if (cond_sel > 4'd9) begin
      a_r9_spare_code_zero: assert (!cond_hit)
        else $error("spare condition code hit");
    end else begin
      a_r9_hit_matches_vec: assert (cond_hit == cond_vec[cond_sel])
        else $error("selected bit mismatch");
    end
  end

endmodule

bind zcmp_top zcmp_checker u_zcmp_checker (
  .operand  (operand),
  .mode     (mode),
  .cond_sel (cond_sel),
  .class_oh (class_oh),
  .cond_vec (cond_vec),
  .cond_hit (cond_hit)
);

// File: tb/zcmp_top_test.sv
module zcmp_top_test;

  logic        clk;
  logic        rst_n;
  logic [63:0] operand;
  logic [1:0]  mode;
  logic [3:0]  cond_sel;
  logic [3:0]  class_oh;
  logic [9:0]  cond_vec;
  logic        cond_hit;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  typedef struct {
    logic [3:0] cls;
    logic [9:0] cv;
    logic       hit;
    string      tag;
  } exp_t;

  exp_t sb_q[$];

  zcmp_top uut (
    .operand  (operand),
    .mode     (mode),
    .cond_sel (cond_sel),
    .class_oh (class_oh),
    .cond_vec (cond_vec),
    .cond_hit (cond_hit)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic exp_t model(input logic [63:0] op, input logic [1:0] md,
                                 input logic [3:0] sel);
    exp_t e;
    logic [10:0] ex = op[62:52];
    logic [51:0] fr = op[51:0];
    logic fp = (md == 2'd0);
    logic nan = 0, zero = 0, neg = 0, pos = 0;
    if (fp) begin
      nan  = (ex == 11'h7FF) && (fr != 0);
      zero = (op[62:0] == 0);
      neg  = op[63] && !zero && !nan;
      pos  = !op[63] && !zero && !nan;
    end else if (md == 2'd1) begin
      zero = (op == 0);
      neg  = op[63];
      pos  = !zero && !neg;
    end else begin
      zero = (op == 0);
      pos  = !zero;
    end
    e.cls   = {nan, pos, neg, zero};
    e.cv    = '0;
    e.cv[0] = zero;
    e.cv[1] = !zero;
    e.cv[2] = neg;
    e.cv[3] = neg || zero;
    e.cv[4] = pos;
    e.cv[5] = pos || zero;
    e.cv[6] = !nan;
    e.cv[7] = nan;
    e.cv[8] = fp && (ex == 11'h7FF) && (fr == 0);
    e.cv[9] = fp && (ex == 0) && (fr != 0);
    e.hit   = (sel < 4'd10) ? e.cv[sel] : 1'b0;
    if (!fp)                              e.tag = (md == 2'd1) ? "R6/R8" : "R7/R8";
    else if (nan)                         e.tag = "R3";
    else if (ex == 0 && fr != 0)          e.tag = "R4";
    else if (ex == 11'h7FF)               e.tag = "R5";
    else if (zero)                        e.tag = "R2";
    else                                  e.tag = "R10";
    return e;
  endfunction

  task automatic drive(input logic [63:0] op, input logic [1:0] md,
                       input logic [3:0] sel);
    @(posedge clk);
    #1;
    operand  = op;
    mode     = md;
    cond_sel = sel;
    sb_q.push_back(model(op, md, sel));
  endtask

  // Monitor: compare outputs at mid-cycle against queued expectations
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_run++;
      if (class_oh !== e.cls) begin
        n_fail++;
        $display("FAIL R1 class op=%h mode=%0d got=%b exp=%b",
                 operand, mode, class_oh, e.cls);
      end
      n_run++;
      if (cond_vec !== e.cv) begin
        n_fail++;
        $display("FAIL %s cond_vec op=%h mode=%0d got=%b exp=%b",
                 e.tag, operand, mode, cond_vec, e.cv);
      end
      n_run++;
      if (cond_hit !== e.hit) begin
        n_fail++;
        $display("FAIL R9 cond_hit op=%h mode=%0d sel=%0d got=%b exp=%b",
                 operand, mode, cond_sel, cond_hit, e.hit);
      end
    end
  end

  logic [63:0] pats [14];

  initial begin
    pats[0]  = 64'h0000_0000_0000_0000; // +0
    pats[1]  = 64'h8000_0000_0000_0000; // -0
    pats[2]  = 64'h0000_0000_0000_0001; // +min denormal
    pats[3]  = 64'h8000_0000_0000_0001; // -min denormal
    pats[4]  = 64'h000F_FFFF_FFFF_FFFF; // +max denormal
    pats[5]  = 64'h3FF0_0000_0000_0000; // +1.0
    pats[6]  = 64'hC000_0000_0000_0000; // -2.0
    pats[7]  = 64'h7FF0_0000_0000_0000; // +inf
    pats[8]  = 64'hFFF0_0000_0000_0000; // -inf
    pats[9]  = 64'h7FF8_0000_0000_0000; // quiet NaN
    pats[10] = 64'h7FF0_0000_0000_0001; // signaling NaN
    pats[11] = 64'hFFF8_0000_0000_0000; // negative NaN
    pats[12] = 64'hFFFF_FFFF_FFFF_FFFF; // integer -1
    pats[13] = 64'h7FFF_FFFF_FFFF_FFFF; // largest positive integer

    rst_n    = 1'b0;
    operand  = '0;
    mode     = 2'd0;
    cond_sel = 4'd0;
    // Reset-time check: +0 in float mode, EQ selected (R2)
    drive(64'd0, 2'd0, 4'd0);
    @(posedge clk);
    rst_n = 1'b1;

    for (int m = 0; m < 4; m++) begin
      for (int p = 0; p < 14; p++) begin
        for (int s = 0; s < 16; s++) begin
          drive(pats[p], 2'(m), 4'(s));
        end
      end
    end
    @(posedge clk);
    @(posedge clk);
    done = 1;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule